// File: doc/BRIEF.md
# Per-CPU Interrupt Claim Port

This block is the slice of a multiprocessor interrupt controller that belongs to one CPU. It collects three kinds of sources into one numbered space. Numbers 0 to 15 are software interrupts, which are held in latches. Numbers 16 to 31 are level lines private to this CPU. Numbers from 32 upward are shared lines that an outside router has already steered to this CPU. For each number the block keeps an enable bit and an active bit. It offers the lowest-numbered candidate for claim and raises a request line to the core while a candidate exists.

Software talks to the block through a small register window, 4 KiB wide, one access per cycle. Enables are switched, and service is ended, by writing an interrupt number to dedicated command offsets rather than by writing bitmaps. A single write to the signal offset sends one software interrupt ID to a whole mask of CPUs. The block emits that request as a one-cycle pulse toward the other CPUs, and it latches the ID locally when the mask includes this CPU.

Top module: `cpu_irq_port`

## Requirements
- R1: After reset the interface enable, every per-interrupt enable, every active flag and every software latch are clear; `irq_req` is low and `rdata` is zero.
- R2: A write of number n to offset 0x0A0 sets the enable of n, and a write to offset 0x0A4 clears it. A value not below the interrupt count (64 by default) changes nothing.
- R3: `irq_req` is high exactly when bit 0 of the control register (offset 0x000) is set and some interrupt is pending, enabled and not active.
- R4: A read of offset 0x0C6 is not a claim. A read of offset 0x06C returns bit 31 set plus the number of the lowest-numbered claimable interrupt in the low bits, and marks that interrupt active.
- R5: An active interrupt is never returned by a claim. It stays that way until its number is written to offset 0x0B4, after which it can be claimed again if it is still pending.
- R6: A claim read with no claimable interrupt, or with the interface disabled, returns zero and changes no enable, active or latch state.
- R7: A read of offset 0x068 returns bit 31 set plus the number of the lowest claimable interrupt, or zero when there is none, and changes no state.
- R8: A write to offset 0x060 makes `ipi_valid` high for exactly the following cycle, with `ipi_id` taken from write bits 3:0 and `ipi_mask` from write bits 8 and up (one bit per CPU).
- R9: Software interrupt n is latched by a pulse on `sw_set[n]`, or by a signal write whose mask bit for this CPU is set. The latch is cleared when that interrupt is claimed. Numbers 16 and up follow their input levels directly.
- R10: A read of offset 0x000 returns the interface enable in bit 0. A read of any offset other than 0x000, 0x068 and 0x06C returns zero.
- R11: Read data appears on `rdata` in the cycle after the read is accepted, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_set | input | 16 | One-cycle pulses that latch software interrupts from other CPUs |
| priv_irq | input | 16 | Level private interrupts, numbers 16 to 31 |
| shared_irq | input | NUM_SHARED | Level shared interrupts routed here, numbers 32 and up |
| req | input | 1 | Register access valid |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W | Byte offset inside the local window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_req | output | 1 | Interrupt request to the core |
| ipi_valid | output | 1 | Outgoing software interrupt pulse |
| ipi_id | output | 4 | Outgoing software interrupt ID |
| ipi_mask | output | NUM_CPUS | Target CPUs of the outgoing software interrupt |

## Verification
The hardest situation to reach from the ports is a crowd of sources that are pending, enabled and active all at once, at several numbers in all three ranges. Only then does the lowest-number pick have to skip over active entries, and only then does a completion re-expose a level source that is still high. The stimulus gets there by running long random stretches where enables and level inputs are dense and claims outnumber completions. Directed sequences around these stretches cover the empty claim, out-of-range numbers and self-targeted signal writes.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int SW_COUNT    = 16;
    localparam int PRIV_COUNT  = 16;
    localparam int LOCAL_COUNT = SW_COUNT + PRIV_COUNT;
    localparam int SW_ID_W     = 4;
    localparam int SIG_MASK_LSB = 8;

    // register offsets inside the per-CPU window
    localparam logic [11:0] OFF_CTRL  = 12'h000;
    localparam logic [11:0] OFF_SIG   = 12'h060;
    localparam logic [11:0] OFF_PEEK  = 12'h068;
    localparam logic [11:0] OFF_CLAIM = 12'h06C;
    localparam logic [11:0] OFF_SETEN = 12'h0A0;
    localparam logic [11:0] OFF_CLREN = 12'h0A4;
    localparam logic [11:0] OFF_DONE  = 12'h0B4;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_CTRL_WR,
        CMD_SIG,
        CMD_SETEN,
        CMD_CLREN,
        CMD_DONE,
        CMD_CLAIM,
        CMD_PEEK,
        CMD_CTRL_RD,
        CMD_RD_ZERO
    } lic_cmd_e;

endpackage

// File: rtl/lic_reg_decode.sv
module lic_reg_decode
    import lic_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output lic_cmd_e          cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (req && we) begin
            unique case (addr)
                ADDR_W'(OFF_CTRL):  cmd = CMD_CTRL_WR;
                ADDR_W'(OFF_SIG):   cmd = CMD_SIG;
                ADDR_W'(OFF_SETEN): cmd = CMD_SETEN;
                ADDR_W'(OFF_CLREN): cmd = CMD_CLREN;
                ADDR_W'(OFF_DONE):  cmd = CMD_DONE;
                default:            cmd = CMD_NONE;
            endcase
        end else if (req) begin
            unique case (addr)
                ADDR_W'(OFF_CTRL):  cmd = CMD_CTRL_RD;
                ADDR_W'(OFF_PEEK):  cmd = CMD_PEEK;
                ADDR_W'(OFF_CLAIM): cmd = CMD_CLAIM;
                default:            cmd = CMD_RD_ZERO;
            endcase
        end
    end

    // a read never decodes to a write-side command
    always_comb begin
        if (req && !we)
            assert_read_not_write_R10: assert (cmd inside {CMD_CTRL_RD, CMD_PEEK, CMD_CLAIM, CMD_RD_ZERO});
    end

endmodule

// File: rtl/lic_prio_pick.sv
module lic_prio_pick #(
    parameter int WIDTH = 64,
    parameter int ID_W  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] cand,
    output logic             valid,
    output logic [ID_W-1:0]  id
);

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        valid = |cand;
        id    = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (cand[i]) id = ID_W'(i);
        end
    end

    always_comb begin
        if (valid)
            assert_pick_is_candidate_R4: assert (cand[id]);
    end

endmodule

// File: rtl/lic_ipi_out.sv
module lic_ipi_out
    import lic_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [SW_ID_W-1:0]  id_in,
    input  logic [NUM_CPUS-1:0] mask_in,
    output logic                ipi_valid,
    output logic [SW_ID_W-1:0]  ipi_id,
    output logic [NUM_CPUS-1:0] ipi_mask
);

    typedef struct packed {
        logic                valid;
        logic [SW_ID_W-1:0]  id;
        logic [NUM_CPUS-1:0] mask;
    } out_t;

    out_t q, d;

    always_comb begin
        d       = q;
        d.valid = fire;
        if (fire) begin
            d.id   = id_in;
            d.mask = mask_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ipi_valid = q.valid;
    assign ipi_id    = q.id;
    assign ipi_mask  = q.mask;

    assert_pulse_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (ipi_valid && ipi_id == $past(id_in) && ipi_mask == $past(mask_in)));

    assert_no_spurious_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !ipi_valid);

endmodule

// File: rtl/cpu_irq_port.sv
module cpu_irq_port
    import lic_pkg::*;
#(
    parameter int NUM_SHARED = 32,
    parameter int NUM_CPUS   = 4,
    parameter int CPU_INDEX  = 0,
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SW_COUNT-1:0]   sw_set,
    input  logic [PRIV_COUNT-1:0] priv_irq,
    input  logic [NUM_SHARED-1:0] shared_irq,
    input  logic                  req,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq_req,
    output logic                  ipi_valid,
    output logic [SW_ID_W-1:0]    ipi_id,
    output logic [NUM_CPUS-1:0]   ipi_mask
);

    localparam int NUM_IRQ = LOCAL_COUNT + NUM_SHARED;
    localparam int ID_W    = $clog2(NUM_IRQ);
    localparam int PAD_W   = DATA_W - 1 - ID_W;

    typedef struct packed {
        logic                ctrl;
        logic [NUM_IRQ-1:0]  en;
        logic [NUM_IRQ-1:0]  act;
        logic [SW_COUNT-1:0] swp;
        logic [DATA_W-1:0]   rdata;
    } state_t;

    state_t q, d;

    lic_cmd_e          cmd;
    logic [NUM_IRQ-1:0] pend;
    logic [NUM_IRQ-1:0] cand;
    logic               pick_valid;
    logic [ID_W-1:0]    pick_id;
    logic [ID_W-1:0]    wid;
    logic               wid_ok;
    logic               sig_fire;
    logic               sig_self;

    lic_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req  (req),
        .we   (we),
        .addr (addr),
        .cmd  (cmd)
    );

    // assemble the numbered source space
    genvar g;
    generate
        for (g = 0; g < NUM_IRQ; g++) begin : g_src
            if (g < SW_COUNT) begin : g_sw
                assign pend[g] = q.swp[g];
            end else if (g < LOCAL_COUNT) begin : g_priv
                assign pend[g] = priv_irq[g - SW_COUNT];
            end else begin : g_shared
                assign pend[g] = shared_irq[g - LOCAL_COUNT];
            end
        end
    endgenerate

    assign cand = pend & q.en & ~q.act & {NUM_IRQ{q.ctrl}};

    lic_prio_pick #(.WIDTH(NUM_IRQ), .ID_W(ID_W)) u_pick (
        .cand  (cand),
        .valid (pick_valid),
        .id    (pick_id)
    );

    assign wid      = wdata[ID_W-1:0];
    assign wid_ok   = (wdata < DATA_W'(NUM_IRQ));
    assign sig_fire = (cmd == CMD_SIG);
    assign sig_self = sig_fire && wdata[SIG_MASK_LSB + CPU_INDEX];

    always_comb begin
        d = q;
        unique case (cmd)
            CMD_CTRL_WR: d.ctrl = wdata[0];
            CMD_SETEN:   if (wid_ok) d.en[wid] = 1'b1;
            CMD_CLREN:   if (wid_ok) d.en[wid] = 1'b0;
            CMD_DONE:    if (wid_ok) d.act[wid] = 1'b0;
            CMD_CLAIM: begin
                if (pick_valid) begin
                    d.act[pick_id] = 1'b1;
                    if (pick_id < ID_W'(SW_COUNT))
                        d.swp[pick_id[SW_ID_W-1:0]] = 1'b0;
                    d.rdata = {1'b1, {PAD_W{1'b0}}, pick_id};
                end else begin
                    d.rdata = '0;
                end
            end
            CMD_PEEK:    d.rdata = {pick_valid, {PAD_W{1'b0}}, pick_id};
            CMD_CTRL_RD: d.rdata = {{(DATA_W-1){1'b0}}, q.ctrl};
            CMD_RD_ZERO: d.rdata = '0;
            default: ;
        endcase
        // new arrivals are applied after a claim has cleared its latch
        if (sig_self) d.swp[wdata[SW_ID_W-1:0]] = 1'b1;
        d.swp = d.swp | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    lic_ipi_out #(.NUM_CPUS(NUM_CPUS)) u_ipi (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (sig_fire),
        .id_in     (wdata[SW_ID_W-1:0]),
        .mask_in   (wdata[SIG_MASK_LSB +: NUM_CPUS]),
        .ipi_valid (ipi_valid),
        .ipi_id    (ipi_id),
        .ipi_mask  (ipi_mask)
    );

    assign rdata   = q.rdata;
    assign irq_req = pick_valid;

    // ---------------- assertions ----------------
    assert_disabled_no_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl |-> !irq_req);

    assert_claim_marks_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CLAIM && pick_valid) |=> (rdata[DATA_W-1] && q.act[rdata[ID_W-1:0]]));

    assert_pick_not_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (!q.act[pick_id] && q.en[pick_id]));

    assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DONE && wid_ok) |=> !q.act[$past(wid)]);

    assert_empty_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CLAIM && !pick_valid) |=> (rdata == '0 && $stable(q.act) && $stable(q.en)));

    assert_peek_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PEEK) |=> ($stable(q.act) && $stable(q.en) && $stable(q.ctrl)));

    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> $stable(rdata));

endmodule

// File: tb/cpu_irq_port_tb.sv
module cpu_irq_port_tb;
    import lic_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSH = 32;
    localparam int NCPU = 4;
    localparam int NI = 32 + NSH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] sw_set = '0;
    logic [15:0] priv_irq = '0;
    logic [NSH-1:0] shared_irq = '0;
    logic req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic irq_req, ipi_valid;
    logic [3:0] ipi_id;
    logic [NCPU-1:0] ipi_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit m_ctrl;
    bit m_en [NI];
    bit m_act [NI];
    bit m_swp [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_irq_port #(.NUM_SHARED(NSH), .NUM_CPUS(NCPU), .CPU_INDEX(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_set(sw_set), .priv_irq(priv_irq),
        .shared_irq(shared_irq), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_req(irq_req), .ipi_valid(ipi_valid), .ipi_id(ipi_id),
        .ipi_mask(ipi_mask)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h at %0t", rq, got, exp, $time);
        end
    endtask

    function automatic bit src(input int i);
        if (i < 16) return m_swp[i];
        if (i < 32) return priv_irq[i-16];
        return shared_irq[i-32];
    endfunction

    function automatic int model_pick();
        for (int i = 0; i < NI; i++)
            if (m_ctrl && m_en[i] && !m_act[i] && src(i)) return i;
        return -1;
    endfunction

    function automatic logic [31:0] fmt(input int p);
        return (p < 0) ? 32'h0 : (32'h8000_0000 | 32'(p));
    endfunction

    task automatic access(input bit w, input logic [11:0] a, input logic [31:0] dv);
        req = 1'b1; we = w; addr = a; wdata = dv;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic post_check(input bit exp_ipi);
        int p;
        p = model_pick();
        check(irq_req == (p >= 0), "R3 irq_req", 32'(irq_req), 32'(p >= 0));
        check(ipi_valid == exp_ipi, "R8 ipi_valid", 32'(ipi_valid), 32'(exp_ipi));
    endtask

    task automatic op_claim(input string rq);
        int p;
        p = model_pick();
        if (p >= 0) begin
            m_act[p] = 1'b1;
            if (p < 16) m_swp[p] = 1'b0;
        end
        access(1'b0, OFF_CLAIM, 32'h0);
        check(rdata == fmt(p), rq, rdata, fmt(p));
        post_check(1'b0);
    endtask

    task automatic op_peek();
        int p;
        p = model_pick();
        access(1'b0, OFF_PEEK, 32'h0);
        check(rdata == fmt(p), "R7 peek", rdata, fmt(p));
        post_check(1'b0);
    endtask

    task automatic op_write(input logic [11:0] a, input logic [31:0] dv);
        bit is_sig;
        is_sig = (a == OFF_SIG);
        if (dv < 32'(NI)) begin
            if (a == OFF_SETEN) m_en[dv] = 1'b1;
            if (a == OFF_CLREN) m_en[dv] = 1'b0;
            if (a == OFF_DONE)  m_act[dv] = 1'b0;
        end
        if (a == OFF_CTRL) m_ctrl = dv[0];
        if (is_sig && dv[8]) m_swp[dv[3:0]] = 1'b1;
        access(1'b1, a, dv);
        if (is_sig) begin
            check(ipi_id == dv[3:0], "R8 ipi_id", 32'(ipi_id), 32'(dv[3:0]));
            check(ipi_mask == dv[8 +: NCPU], "R8 ipi_mask", 32'(ipi_mask), 32'(dv[8 +: NCPU]));
        end
        post_check(is_sig);
    endtask

    task automatic op_swpulse(input logic [15:0] v);
        sw_set = v;
        for (int i = 0; i < 16; i++) if (v[i]) m_swp[i] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sw_set = '0;
        post_check(1'b0);
    endtask

    task automatic op_levels(input logic [15:0] pv, input logic [NSH-1:0] sv);
        priv_irq = pv;
        shared_irq = sv;
        @(posedge clk);
        @(negedge clk);
        post_check(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ctrl = 1'b0;
        for (int i = 0; i < NI; i++) begin m_en[i] = 1'b0; m_act[i] = 1'b0; end
        for (int i = 0; i < 16; i++) m_swp[i] = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq_req == 1'b0, "R1 irq_req", 32'(irq_req), 32'h0);
        check(rdata == 32'h0, "R1 rdata", rdata, 32'h0);
        access(1'b0, OFF_CTRL, 32'h0);
        check(rdata == 32'h0, "R1 ctrl reset", rdata, 32'h0);

        // R3/R6: pending and enabled but interface off -> nothing
        op_write(OFF_SETEN, 32'd20);
        op_levels(16'h0010, '0);
        check(irq_req == 1'b0, "R3 off gate", 32'(irq_req), 32'h0);
        op_claim("R6 claim while off");

        // R10 control readback and unmapped read
        op_write(OFF_CTRL, 32'h1);
        access(1'b0, OFF_CTRL, 32'h0);
        check(rdata == 32'h1, "R10 ctrl read", rdata, 32'h1);
        access(1'b0, 12'h100, 32'h0);
        check(rdata == 32'h0, "R10 unmapped", rdata, 32'h0);
        post_check(1'b0);

        // R11 read data holds across non-read cycles
        op_peek();
        op_levels(16'h0010, '0);
        check(rdata == 32'h8000_0014, "R11 hold", rdata, 32'h8000_0014);

        // R2 out-of-range enable ignored (64 is not a valid number)
        op_write(OFF_SETEN, 32'd64);
        op_write(OFF_SETEN, 32'h0000_0105);
        // R4/R9 priority across ranges: sw 5, priv 20, shared 40
        op_write(OFF_SETEN, 32'd5);
        op_write(OFF_SETEN, 32'd40);
        op_swpulse(16'h0020);
        op_levels(16'h0010, 32'h0000_0100);
        op_claim("R4 first sw5");
        op_claim("R4 second priv20");
        op_claim("R4 third shared40");
        op_claim("R6 empty claim");
        op_peek();
        // R5 completion re-exposes a still-high level
        op_write(OFF_DONE, 32'd20);
        op_claim("R5 reclaim priv20");
        // R9 software latch was cleared by claim: completion of 5 brings nothing back
        op_write(OFF_DONE, 32'd5);
        op_claim("R9 sw latch cleared");
        // R2 disable
        op_write(OFF_DONE, 32'd20);
        op_write(OFF_CLREN, 32'd20);
        op_claim("R2 disabled not claimed");

        // R8/R9 self-targeted signal and remote-only signal
        op_write(OFF_SETEN, 32'd3);
        op_write(OFF_SIG, 32'h0000_0E03);
        op_claim("R9 remote-only sig no latch");
        op_write(OFF_SIG, 32'h0000_0103);
        op_claim("R9 self sig latched");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            int k;
            k = $urandom_range(0, 99);
            if (k < 12)       op_write(OFF_SETEN, $urandom_range(0, NI + 3));
            else if (k < 16)  op_write(OFF_CLREN, $urandom_range(0, NI + 3));
            else if (k < 38)  op_claim("R4 random claim");
            else if (k < 46)  op_peek();
            else if (k < 60)  op_write(OFF_DONE, $urandom_range(0, NI + 3));
            else if (k < 66)  op_write(OFF_SIG, $urandom() & 32'h0000_0F0F);
            else if (k < 74)  op_swpulse(16'($urandom() & $urandom()));
            else if (k < 86)  op_levels(16'($urandom() & $urandom()), $urandom() & $urandom());
            else if (k < 88)  op_write(OFF_CTRL, ($urandom_range(0, 3) != 0) ? 32'h1 : 32'h0);
            else begin
                access(1'b0, OFF_CTRL, 32'h0);
                check(rdata == 32'(m_ctrl), "R10 ctrl random", rdata, 32'(m_ctrl));
                post_check(1'b0);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule